// File: doc/BRIEF.md
# Instant-Completion Sideband Command Register Stub

This block has the register interface of a host controller for a sideband thermal-management command bus. It has no physical layer. Software sees a 4 KiB window on a 32-bit register bus. The window holds a small array of sixteen 32-bit words, and all of them reset to zero. A command is started by writing 1 to bit 0 of the command word. The block never sends anything on a wire. In the same cycle as the write, it puts the success completion code 0x40 into the first transmit buffer word and the first receive buffer word. It then posts a command-done status, masked by the interrupt enable word.

The status word is cleared by writing ones (write-one-to-clear). A level interrupt output stays high while any status bit is set. The block refuses a new command until software has cleared the pending status. Accesses beyond the array are dropped, and reads there return zero. Firmware and driver code can therefore run their full command flow against this stub without a real bus attached.

Top module: `sbcmd_stub`

## Requirements
- R1: After reset every in-range word reads 0 and `irq_o` is low.
- R2: A write to any in-range word other than the command word (0x08) and the status word (0x1C) stores all 32 bits. A read at that address returns them. Address bits [1:0] are ignored.
- R3: The command word at 0x08 always reads 0. Only its bit 0 (start) has any effect.
- R4: A write to 0x08 with bit 0 set, while the status word is zero, loads 0x40 into both the transmit buffer word 0x20 and the receive buffer word 0x30.
- R5: That accepted start sets the status word (0x1C) to the enable word (0x18) ANDed with 0x1, where bit 0 is command-done.
- R6: `irq_o` is high exactly when the status word is nonzero. It changes at the same clock edge as the status word.
- R7: A write to 0x1C clears every status bit that is written as 1 and leaves the other status bits unchanged.
- R8: A start write while the status word is nonzero is refused. The buffers and the status word keep their values.
- R9: A write to 0x08 with bit 0 clear changes no state.
- R10: A write at address 0x40 or above changes no word, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address inside the 4 KiB window |
| we_i | input | 1 | Write strobe; the write takes effect at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
Read data is combinational. A read is therefore due in the same cycle that the address is driven, and the bench compares it at the falling edge of that cycle. Each write, including a start or a clear, takes effect at the one rising edge where `we_i` is high. Buffer words, the status word and `irq_o` all hold their new values from that edge on. The driver drops `we_i` 2 ns after that edge and queues each expected read or interrupt value only after it has driven the matching address. The monitor compares at the next falling edge, so every check falls at least one full edge after the write that caused it.

// File: rtl/sbcmd_pkg.sv
package sbcmd_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned NUM_WORDS = 16;
  // word indices that carry behaviour
  localparam int unsigned CMD_IDX   = 2;
  localparam int unsigned CTRL_IDX  = 6;
  localparam int unsigned STS_IDX   = 7;
  localparam int unsigned TXB_IDX   = 8;
  localparam int unsigned RXB_IDX   = 12;
  localparam logic [7:0]  OK_CODE   = 8'h40;

  typedef enum logic [1:0] {
    WK_NONE,
    WK_PLAIN,
    WK_CMD,
    WK_CLEAR
  } wr_kind_e;
endpackage

// File: rtl/sbcmd_decode.sv
module sbcmd_decode
  import sbcmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = sbcmd_pkg::ADDR_W,
  parameter int unsigned NUM_WORDS = sbcmd_pkg::NUM_WORDS,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              in_range_o,
  output logic [IDX_W-1:0]  idx_o,
  output wr_kind_e          kind_o
);
  localparam logic [ADDR_W-3:0] LIMIT = (ADDR_W-2)'(NUM_WORDS);

  logic [ADDR_W-3:0] word;
  assign word       = addr_i[ADDR_W-1:2];
  assign in_range_o = word < LIMIT;
  assign idx_o      = word[IDX_W-1:0];

  always_comb begin
    kind_o = WK_NONE;
    if (we_i && in_range_o) begin
      if (idx_o == IDX_W'(CMD_IDX))      kind_o = WK_CMD;
      else if (idx_o == IDX_W'(STS_IDX)) kind_o = WK_CLEAR;
      else                               kind_o = WK_PLAIN;
    end
  end
endmodule

// File: rtl/sbcmd_fire.sv
module sbcmd_fire
  import sbcmd_pkg::*;
#(
  parameter int unsigned DATA_W = sbcmd_pkg::DATA_W
) (
  input  wr_kind_e          kind_i,
  input  logic              start_bit_i,
  input  logic [DATA_W-1:0] sts_i,
  output logic              fire_o
);
  // refused while any status bit is pending
  assign fire_o = (kind_i == WK_CMD) && start_bit_i && (sts_i == '0);
endmodule

// File: rtl/sbcmd_regs.sv
module sbcmd_regs
  import sbcmd_pkg::*;
#(
  parameter int unsigned DATA_W    = sbcmd_pkg::DATA_W,
  parameter int unsigned NUM_WORDS = sbcmd_pkg::NUM_WORDS,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_kind_e          kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] sts_o,
  output logic [DATA_W-1:0] sts_next_o
);
  localparam logic [DATA_W-1:0] DONE_BIT = DATA_W'(1);
  localparam logic [DATA_W-1:0] CODE_W   = DATA_W'(OK_CODE);

  logic [DATA_W-1:0] word_q [NUM_WORDS];
  logic [DATA_W-1:0] word_d [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    if (g == CMD_IDX) begin : g_cmd
      // start bit is never stored
      assign word_q[g] = '0;
      assign word_d[g] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] cur_q, nxt;
      logic              hit;
      assign hit = (idx_i == IDX_W'(g));

      always_comb begin
        nxt = cur_q;
        if (kind_i == WK_PLAIN && hit) nxt = wdata_i;
        if (g == STS_IDX) begin
          if (kind_i == WK_CLEAR) nxt = cur_q & ~wdata_i;
          if (fire_i)             nxt = word_q[CTRL_IDX] & DONE_BIT;
        end
        if (g == TXB_IDX || g == RXB_IDX) begin
          if (fire_i) nxt = CODE_W;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt;
      end

      assign word_q[g] = cur_q;
      assign word_d[g] = nxt;
    end
  end

  assign rdata_o    = word_q[idx_i];
  assign ctrl_o     = word_q[CTRL_IDX];
  assign sts_o      = word_q[STS_IDX];
  assign sts_next_o = word_d[STS_IDX];
endmodule

// File: rtl/sbcmd_irq.sv
module sbcmd_irq #(
  parameter int unsigned DATA_W = sbcmd_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sts_next_i,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |sts_next_i;
  end
endmodule

// File: rtl/sbcmd_stub.sv
module sbcmd_stub
  import sbcmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = sbcmd_pkg::ADDR_W,
  parameter int unsigned DATA_W    = sbcmd_pkg::DATA_W,
  parameter int unsigned NUM_WORDS = sbcmd_pkg::NUM_WORDS,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  wr_kind_e          kind;
  logic              fire;
  logic [DATA_W-1:0] word_rd, ctrl_w, sts_w, sts_nxt;

  sbcmd_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .addr_i     (addr_i),
    .we_i       (we_i),
    .in_range_o (in_range),
    .idx_o      (idx),
    .kind_o     (kind)
  );

  sbcmd_fire #(.DATA_W(DATA_W)) u_fire (
    .kind_i      (kind),
    .start_bit_i (wdata_i[0]),
    .sts_i       (sts_w),
    .fire_o      (fire)
  );

  sbcmd_regs #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .idx_i      (idx),
    .wdata_i    (wdata_i),
    .fire_i     (fire),
    .rdata_o    (word_rd),
    .ctrl_o     (ctrl_w),
    .sts_o      (sts_w),
    .sts_next_o (sts_nxt)
  );

  sbcmd_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sts_next_i (sts_nxt),
    .irq_o      (irq_o)
  );

  assign rdata_o = in_range ? word_rd : '0;
endmodule

// File: rtl/sbcmd_chk.sv
module sbcmd_chk
  import sbcmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = sbcmd_pkg::ADDR_W,
  parameter int unsigned DATA_W    = sbcmd_pkg::DATA_W,
  parameter int unsigned NUM_WORDS = sbcmd_pkg::NUM_WORDS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] ctrl_i,
  input logic [DATA_W-1:0] sts_i
);
  localparam logic [ADDR_W-3:0] LIMIT = (ADDR_W-2)'(NUM_WORDS);

  logic [ADDR_W-3:0] word;
  logic in_rng, cmd_wr, sts_wr, start_ok;
  assign word     = addr_i[ADDR_W-1:2];
  assign in_rng   = word < LIMIT;
  assign cmd_wr   = we_i && word == (ADDR_W-2)'(CMD_IDX);
  assign sts_wr   = we_i && word == (ADDR_W-2)'(STS_IDX);
  assign start_ok = cmd_wr && wdata_i[0] && sts_i == '0;

  p_cmd_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word == (ADDR_W-2)'(CMD_IDX)) |-> rdata_o == '0);

  p_start_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> sts_i == ($past(ctrl_i) & DATA_W'(1)));

  p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (sts_i != '0));

  p_irq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && ctrl_i[0]) |=> irq_o);

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr |=> sts_i == ($past(sts_i) & ~$past(wdata_i)));

  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && sts_i != '0) |=> sts_i == $past(sts_i));

  p_oob_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rng |-> rdata_o == '0);
endmodule

bind sbcmd_stub sbcmd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .ctrl_i  (ctrl_w),
  .sts_i   (sts_w)
);

// File: tb/tb_sbcmd_stub.sv
module tb_sbcmd_stub;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  sbcmd_stub dut (.*);

  always #5 clk_i = ~clk_i;

  // monitor: compare at falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb_q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : rdata_o;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, addr_i, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk_i); #2;
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #2;
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(posedge clk_i); #2;
    addr_i = a;
    sb_q.push_back('{1'b0, e, tag});
    @(negedge clk_i); #1;
  endtask

  task automatic irq_chk(input bit e, input string tag);
    @(posedge clk_i); #2;
    sb_q.push_back('{1'b1, {31'b0, e}, tag});
    @(negedge clk_i); #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    // R1 reset state
    rd(12'h000, 32'h0, "R1");
    rd(12'h018, 32'h0, "R1");
    rd(12'h01C, 32'h0, "R1");
    rd(12'h020, 32'h0, "R1");
    rd(12'h030, 32'h0, "R1");
    rd(12'h03C, 32'h0, "R1");
    irq_chk(1'b0, "R1");

    // R2 plain storage, byte offset bits ignored
    wr(12'h000, 32'hA5A5_5A5A);
    rd(12'h000, 32'hA5A5_5A5A, "R2");
    wr(12'h03C, 32'hFFFF_0001);
    rd(12'h03C, 32'hFFFF_0001, "R2");
    wr(12'h027, 32'h1234_5678);
    rd(12'h024, 32'h1234_5678, "R2");

    // R9 command write without start bit
    wr(12'h020, 32'hCAFE_0000);
    wr(12'h008, 32'hFFFF_FFFE);
    rd(12'h020, 32'hCAFE_0000, "R9");
    rd(12'h01C, 32'h0, "R9");
    rd(12'h008, 32'h0, "R3");
    irq_chk(1'b0, "R9");

    // start with done interrupt disabled
    wr(12'h018, 32'h0);
    wr(12'h008, 32'h1);
    rd(12'h020, 32'h40, "R4");
    rd(12'h030, 32'h40, "R4");
    rd(12'h01C, 32'h0, "R5");
    irq_chk(1'b0, "R6");
    rd(12'h008, 32'h0, "R3");

    // start with enable word all ones
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h020, 32'h11);
    wr(12'h008, 32'h1);
    rd(12'h01C, 32'h1, "R5");
    irq_chk(1'b1, "R6");
    rd(12'h020, 32'h40, "R4");

    // R8 start refused while pending
    wr(12'h020, 32'h2222);
    wr(12'h030, 32'h3333);
    wr(12'h008, 32'h1);
    rd(12'h020, 32'h2222, "R8");
    rd(12'h030, 32'h3333, "R8");
    rd(12'h01C, 32'h1, "R8");
    irq_chk(1'b1, "R8");

    // R7 write-one-to-clear
    wr(12'h01C, 32'hFFFF_FFFE);
    rd(12'h01C, 32'h1, "R7");
    irq_chk(1'b1, "R7");
    wr(12'h01C, 32'h1);
    rd(12'h01C, 32'h0, "R7");
    irq_chk(1'b0, "R6");

    // restart after clear
    wr(12'h008, 32'h1);
    rd(12'h020, 32'h40, "R4");
    rd(12'h030, 32'h40, "R4");
    irq_chk(1'b1, "R6");
    wr(12'h01C, 32'h1);

    // R10 out of range
    wr(12'h020, 32'h5555);
    wr(12'h040, 32'hDEAD_BEEF);
    rd(12'h000, 32'hA5A5_5A5A, "R10");
    rd(12'h040, 32'h0, "R10");
    rd(12'hFFC, 32'h0, "R10");
    wr(12'h048, 32'h1);
    rd(12'h020, 32'h5555, "R10");
    rd(12'h01C, 32'h0, "R10");
    irq_chk(1'b0, "R10");

    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule